// File: doc/BRIEF.md
# Mini UART Register Front-End

This block is the software-visible face of a small UART. It answers word-wide reads and writes in a 256-byte register window. Received bytes arrive on a byte stream with a ready/valid handshake and are queued in a circular receive queue. Software drains the queue through the data register. A data-register write sends its low byte out on a transmit stream as a one-cycle strobe.

Serial framing and bit timing sit behind the transmit and receive streams and are not part of this block. The transmit side is modelled as permanently empty and idle, so the transmit interrupt depends only on its enable bit. One level-sensitive interrupt line combines the receive and transmit conditions. The line-control, modem-control, modem-status, scratch and baud registers are placeholders: they read as zero and ignore writes.

Register offsets (byte addresses; bits [1:0] of the address are ignored):

| Offset | Register |
|---|---|
| 0x00 | interrupt status |
| 0x04 | enables |
| 0x40 | data |
| 0x44 | interrupt enable |
| 0x48 | interrupt identify |
| 0x4C | line control (placeholder) |
| 0x50 | modem control (placeholder) |
| 0x54 | line status |
| 0x58 | modem status (placeholder) |
| 0x5C | scratch (placeholder) |
| 0x60 | extra control |
| 0x64 | extended status |
| 0x68 | baud (placeholder) |

Timing is the same for every register. An access is sampled on the clock edge where `bus_sel` is high. Read data appears on `bus_rdata` after that edge and holds until the next read. Side effects take place on that same edge.

Top module: `mu_regfront`

## Requirements
- R1: After reset the receive queue is empty and every one of its entries is zero. Both interrupt enables are clear, `irq` is low, `rx_ready` is high and `tx_valid` is low.
- R2: A write to the interrupt enable register (0x44) stores only bits [1:0]: bit 0 enables receive and bit 1 enables transmit. A read returns 0xC0 ORed with those two bits. No other access changes them.
- R3: Receive-pending is set when bit 0 is enabled and the queue is not empty. Transmit-pending is set whenever bit 1 is enabled. `irq` is high when either is pending. The interrupt status register (0x00) reads 1 when `irq` is high and 0 otherwise.
- R4: The interrupt identify register (0x48) reads 0xC0 ORed with two fields. The first is 0x4 when the queue holds data and 0x2 when it is empty. The second is bit 0, set when no interrupt is pending.
- R5: A write to 0x48 with bit 1 set empties the queue. A write to 0x48 with bit 1 clear leaves the queue untouched.
- R6: A data-register read (0x40) returns the entry at the read pointer. When the queue is non-empty the pointer then advances, wrapping after the last entry, and the count drops by one. On an empty queue the read returns that stale entry and changes nothing.
- R7: The queue holds 8 bytes. A byte is taken only while fewer than 8 are held, and `rx_ready` is low exactly when 8 are held. Bytes offered while the queue is full are lost. Bytes leave in the order they arrived.
- R8: Line status (0x54) reads 0x60 ORed with bit 0, which is set when the queue holds data.
- R9: Extended status (0x64) reads 0x30E. When the queue holds data it also has bit 0 set and the fill count in bits [19:16].
- R10: The enables register (0x04) reads 1 and extra control (0x60) reads 0x3.
- R11: A data-register write drives `tx_valid` high for exactly one cycle after the access edge, with `tx_data` equal to write bits [7:0].
- R12: Placeholder registers and unlisted offsets read as zero. Writes to them change neither the enables nor the queue, and they raise no transmit strobe.
- R13: A flush write and an accepted receive byte on the same edge leave exactly that new byte in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Queue can take a byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a full queue whose read pointer is not at entry zero. That state is needed to check wrap-around in both pointers, the refusal of a ninth byte and the stale-entry read. The bench first pushes and drains three bytes to move the pointer, then fills all eight slots, offers a byte that must be refused, and drains the queue. A final read of the empty queue then has to return the first byte of that batch. The flush-and-push collision is driven in a single cycle by raising the receive handshake during the identify-register write.

// File: rtl/mu_pkg.sv
package mu_pkg;

    // byte offsets inside the 256-byte window
    localparam logic [7:0] OFS_ISTAT     = 8'h00;
    localparam logic [7:0] OFS_ENABLE    = 8'h04;
    localparam logic [7:0] OFS_DATA      = 8'h40;
    localparam logic [7:0] OFS_IEN       = 8'h44;
    localparam logic [7:0] OFS_IDENT     = 8'h48;
    localparam logic [7:0] OFS_LINECTL   = 8'h4C;
    localparam logic [7:0] OFS_MODEMCTL  = 8'h50;
    localparam logic [7:0] OFS_LINESTAT  = 8'h54;
    localparam logic [7:0] OFS_MODEMSTAT = 8'h58;
    localparam logic [7:0] OFS_SCRATCH   = 8'h5C;
    localparam logic [7:0] OFS_XCTL      = 8'h60;
    localparam logic [7:0] OFS_XSTAT     = 8'h64;
    localparam logic [7:0] OFS_BAUD      = 8'h68;

    // constant patterns merged into read words
    localparam logic [31:0] IEN_RD_BASE  = 32'h0000_00C0;
    localparam logic [31:0] IDENT_BASE   = 32'h0000_00C0;
    localparam logic [31:0] IDENT_RXCODE = 32'h0000_0004;
    localparam logic [31:0] IDENT_TXCODE = 32'h0000_0002;
    localparam logic [31:0] IDENT_NONE   = 32'h0000_0001;
    localparam logic [31:0] LSTAT_BASE   = 32'h0000_0060;
    localparam logic [31:0] XSTAT_BASE   = 32'h0000_030E;
    localparam logic [31:0] ENABLE_VAL   = 32'h0000_0001;
    localparam logic [31:0] XCTL_VAL     = 32'h0000_0003;

    localparam int unsigned IEN_RX_BIT    = 0;
    localparam int unsigned IEN_TX_BIT    = 1;
    localparam int unsigned FLUSH_BIT     = 1;
    localparam int unsigned XSTAT_CNT_LSB = 16;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ISTAT,
        SEL_ENABLE,
        SEL_DATA,
        SEL_IEN,
        SEL_IDENT,
        SEL_LSTAT,
        SEL_XCTL,
        SEL_XSTAT,
        SEL_HOLE
    } reg_sel_e;

    // word-granular decode: address bits [1:0] do not take part
    function automatic reg_sel_e decode_reg(input logic [7:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if      (a[7:2] == OFS_ISTAT[7:2])     s = SEL_ISTAT;
        else if (a[7:2] == OFS_ENABLE[7:2])    s = SEL_ENABLE;
        else if (a[7:2] == OFS_DATA[7:2])      s = SEL_DATA;
        else if (a[7:2] == OFS_IEN[7:2])       s = SEL_IEN;
        else if (a[7:2] == OFS_IDENT[7:2])     s = SEL_IDENT;
        else if (a[7:2] == OFS_LINESTAT[7:2])  s = SEL_LSTAT;
        else if (a[7:2] == OFS_XCTL[7:2])      s = SEL_XCTL;
        else if (a[7:2] == OFS_XSTAT[7:2])     s = SEL_XSTAT;
        else if (a[7:2] == OFS_LINECTL[7:2] || a[7:2] == OFS_MODEMCTL[7:2] ||
                 a[7:2] == OFS_MODEMSTAT[7:2] || a[7:2] == OFS_SCRATCH[7:2] ||
                 a[7:2] == OFS_BAUD[7:2])      s = SEL_HOLE;
        return s;
    endfunction

endpackage

// File: rtl/mu_rxq.sv
module mu_rxq #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    output logic          push_ready,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          nonempty
);

    localparam int unsigned SW = CW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            rd_ptr;
        logic [CW-1:0]            count;
    } rxq_st_t;

    rxq_st_t st_q, st_d;

    logic          push_ok;
    logic          pop_ok;
    logic [CW-1:0] base_cnt;
    logic [SW-1:0] slot_sum;
    logic [SW-1:0] slot_mod;
    logic [PW-1:0] wr_slot;

    assign push_ready = (st_q.count < CW'(DEPTH));
    assign head       = st_q.mem[st_q.rd_ptr];
    assign count      = st_q.count;
    assign nonempty   = (st_q.count != '0);

    always_comb begin
        st_d     = st_q;
        push_ok  = push_valid && push_ready;
        pop_ok   = pop && (st_q.count != '0) && !flush;
        // a flush on this edge moves the write slot back to the read pointer
        base_cnt = flush ? '0 : st_q.count;
        slot_sum = SW'(st_q.rd_ptr) + SW'(base_cnt);
        slot_mod = (slot_sum >= SW'(DEPTH)) ? (slot_sum - SW'(DEPTH)) : slot_sum;
        wr_slot  = slot_mod[PW-1:0];

        if (push_ok) begin
            st_d.mem[wr_slot] = push_data;
        end

        if (pop_ok) begin
            if (st_q.rd_ptr == PW'(DEPTH - 1)) begin
                st_d.rd_ptr = '0;
            end else begin
                st_d.rd_ptr = st_q.rd_ptr + PW'(1);
            end
        end

        st_d.count = base_cnt;
        if (pop_ok && !push_ok) begin
            st_d.count = base_cnt - CW'(1);
        end else if (push_ok && !pop_ok) begin
            st_d.count = base_cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH)) else $error("queue count above depth"); // R7

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !push_valid) |=> (st_q.count == '0)) else $error("flush left data"); // R5

    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && st_q.count == '0 && !push_valid && !flush) |=>
        ($stable(st_q.rd_ptr) && st_q.count == '0)) else $error("empty read moved state"); // R6

endmodule

// File: rtl/mu_irq.sv
module mu_irq (
    input  logic [1:0] ien,
    input  logic       rx_nonempty,
    output logic       pend_rx,
    output logic       pend_tx,
    output logic       pend_any
);
    import mu_pkg::*;

    always_comb begin
        pend_rx  = ien[IEN_RX_BIT] && rx_nonempty;
        // transmit path is always drained, so only the enable matters
        pend_tx  = ien[IEN_TX_BIT];
        pend_any = pend_rx || pend_tx;
    end

endmodule

// File: rtl/mu_rdmux.sv
module mu_rdmux #(
    parameter int unsigned DW = 8,
    parameter int unsigned CW = 4
) (
    input  mu_pkg::reg_sel_e sel,
    input  logic [1:0]       ien,
    input  logic [CW-1:0]    count,
    input  logic             nonempty,
    input  logic [DW-1:0]    head,
    input  logic             pend_any,
    output logic [31:0]      rd_word
);
    import mu_pkg::*;

    logic [31:0] ident_word;
    logic [31:0] xstat_word;

    always_comb begin
        ident_word = IDENT_BASE | (nonempty ? IDENT_RXCODE : IDENT_TXCODE);
        if (!pend_any) begin
            ident_word = ident_word | IDENT_NONE;
        end

        xstat_word = XSTAT_BASE;
        if (nonempty) begin
            xstat_word = xstat_word | 32'h1 | (32'(count) << XSTAT_CNT_LSB);
        end

        unique case (sel)
            SEL_ISTAT:  rd_word = {31'b0, pend_any};
            SEL_ENABLE: rd_word = ENABLE_VAL;
            SEL_DATA:   rd_word = 32'(head);
            SEL_IEN:    rd_word = IEN_RD_BASE | {30'b0, ien};
            SEL_IDENT:  rd_word = ident_word;
            SEL_LSTAT:  rd_word = LSTAT_BASE | {31'b0, nonempty};
            SEL_XCTL:   rd_word = XCTL_VAL;
            SEL_XSTAT:  rd_word = xstat_word;
            default:    rd_word = '0;
        endcase
    end

endmodule

// File: rtl/mu_regfront.sv
module mu_regfront #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [7:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          irq
);
    import mu_pkg::*;

    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [1:0]    ien;
        logic [31:0]   rdata;
        logic          tx_valid;
        logic [DW-1:0] tx_data;
    } front_st_t;

    front_st_t st_q, st_d;

    reg_sel_e      sel;
    logic          acc_rd;
    logic          acc_wr;
    logic          q_pop;
    logic          q_flush;
    logic [DW-1:0] q_head;
    logic [CW-1:0] q_count;
    logic          q_nonempty;
    logic          pend_rx;
    logic          pend_tx;
    logic          pend_any;
    logic [31:0]   rd_word;

    assign sel     = decode_reg(bus_addr);
    assign acc_rd  = bus_sel && !bus_wr;
    assign acc_wr  = bus_sel && bus_wr;
    assign q_pop   = acc_rd && (sel == SEL_DATA);
    assign q_flush = acc_wr && (sel == SEL_IDENT) && bus_wdata[FLUSH_BIT];

    mu_rxq #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_rxq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (rx_valid),
        .push_data  (rx_data),
        .push_ready (rx_ready),
        .pop        (q_pop),
        .flush      (q_flush),
        .head       (q_head),
        .count      (q_count),
        .nonempty   (q_nonempty)
    );

    mu_irq u_irq (
        .ien         (st_q.ien),
        .rx_nonempty (q_nonempty),
        .pend_rx     (pend_rx),
        .pend_tx     (pend_tx),
        .pend_any    (pend_any)
    );

    mu_rdmux #(
        .DW (DW),
        .CW (CW)
    ) u_rdmux (
        .sel      (sel),
        .ien      (st_q.ien),
        .count    (q_count),
        .nonempty (q_nonempty),
        .head     (q_head),
        .pend_any (pend_any),
        .rd_word  (rd_word)
    );

    always_comb begin
        st_d          = st_q;
        st_d.tx_valid = 1'b0;
        if (acc_wr) begin
            unique case (sel)
                SEL_IEN: begin
                    st_d.ien = bus_wdata[1:0];
                end
                SEL_DATA: begin
                    st_d.tx_valid = 1'b1;
                    st_d.tx_data  = bus_wdata[DW-1:0];
                end
                default: begin
                end
            endcase
        end
        if (acc_rd) begin
            st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign tx_valid  = st_q.tx_valid;
    assign tx_data   = st_q.tx_data;
    assign irq       = pend_rx || pend_tx;

    AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bus_sel && bus_wr && bus_addr[7:2] == OFS_DATA[7:2]))
        else $error("transmit strobe without data write"); // R11

    AST_IEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr[7:2] == OFS_IEN[7:2]) |=> $stable(st_q.ien))
        else $error("enables changed without enable write"); // R2

endmodule

// File: tb/mu_regfront_test.sv
module mu_regfront_test;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    // independent ring model of the receive queue
    logic [7:0] mdl_mem [DEPTH];
    int         mdl_rd = 0;
    int         mdl_cnt = 0;

    always #10 clk = ~clk;

    mu_regfront uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        chk(req, v, exp);
    endtask

    task automatic mdl_push(input logic [7:0] b);
        if (mdl_cnt < DEPTH) begin
            mdl_mem[(mdl_rd + mdl_cnt) % DEPTH] = b;
            mdl_cnt++;
        end
    endtask

    task automatic rx_push(input logic [7:0] b);
        logic rdy;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rdy = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
        if (rdy) mdl_push(b);
    endtask

    task automatic pop_chk(input string req);
        logic [7:0] e;
        e = mdl_mem[mdl_rd];
        if (mdl_cnt > 0) begin
            mdl_rd = (mdl_rd + 1) % DEPTH;
            mdl_cnt--;
        end
        rd_chk(req, 8'h40, 32'(e));
    endtask

    function automatic logic [31:0] xstat_exp();
        if (mdl_cnt == 0) return 32'h30E;
        return 32'h30F | (32'(mdl_cnt) << 16);
    endfunction

    task automatic t_reset();
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rx_ready", 32'(rx_ready), 1);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        rd_chk("R1 R8 line status empty", 8'h54, 32'h60);
        rd_chk("R1 R2 enable reg", 8'h44, 32'hC0);
        rd_chk("R1 R4 identify idle", 8'h48, 32'hC3);
        rd_chk("R1 R9 ext status", 8'h64, 32'h30E);
    endtask

    task automatic t_enables();
        bus_write(8'h44, 32'hFFFF_FFFF);
        rd_chk("R2 enable keeps two bits", 8'h44, 32'hC3);
        chk("R3 tx enable raises irq", 32'(irq), 1);
        rd_chk("R3 interrupt status set", 8'h00, 32'h1);
        rd_chk("R4 identify tx pending", 8'h48, 32'hC2);
        bus_write(8'h44, 32'h0);
        chk("R3 irq low when disabled", 32'(irq), 0);
        rd_chk("R3 interrupt status clear", 8'h00, 32'h0);
    endtask

    task automatic t_fixed();
        rd_chk("R10 enables reads 1", 8'h04, 32'h1);
        rd_chk("R10 extra control", 8'h60, 32'h3);
        rd_chk("R12 line ctl zero", 8'h4C, 32'h0);
        rd_chk("R12 modem status zero", 8'h58, 32'h0);
        rd_chk("R12 baud zero", 8'h68, 32'h0);
        rd_chk("R12 unlisted zero", 8'hA0, 32'h0);
    endtask

    task automatic t_order();
        rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
        rd_chk("R8 line status data", 8'h54, 32'h61);
        rd_chk("R9 ext status count 3", 8'h64, xstat_exp());
        rd_chk("R4 identify rx no pend", 8'h48, 32'hC5);
        chk("R3 rx disabled no irq", 32'(irq), 0);
        bus_write(8'h44, 32'h1);
        chk("R3 rx pending irq", 32'(irq), 1);
        rd_chk("R4 identify rx pending", 8'h48, 32'hC4);
        pop_chk("R6 pop first");
        pop_chk("R6 pop second");
        pop_chk("R6 pop third");
        chk("R3 irq drops when empty", 32'(irq), 0);
        bus_write(8'h44, 32'h0);
    endtask

    task automatic t_full_wrap();
        for (int i = 0; i < DEPTH; i++) rx_push(8'hA0 + 8'(i));
        chk("R7 not ready when full", 32'(rx_ready), 0);
        rx_push(8'hEE);
        rd_chk("R9 ext status full", 8'h64, 32'h8030F);
        for (int i = 0; i < DEPTH; i++) pop_chk("R6 R7 wrap order");
        chk("R7 ready after drain", 32'(rx_ready), 1);
        pop_chk("R6 empty read stale entry");
        rd_chk("R6 empty read no change", 8'h64, 32'h30E);
    endtask

    task automatic t_flush();
        rx_push(8'h5A); rx_push(8'h6B);
        bus_write(8'h48, 32'h1);
        rd_chk("R5 bit1 clear keeps data", 8'h64, xstat_exp());
        bus_write(8'h48, 32'h2);
        mdl_cnt = 0;
        rd_chk("R5 flush empties", 8'h54, 32'h60);
        rx_push(8'h01); rx_push(8'h02);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h2;
        rx_valid = 1'b1; rx_data = 8'h77;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
        mdl_cnt = 0;
        mdl_push(8'h77);
        rd_chk("R13 flush plus push count 1", 8'h64, 32'h1030F);
        pop_chk("R13 surviving byte");
    endtask

    task automatic t_tx();
        bus_write(8'h40, 32'h0000_01A5);
        chk("R11 strobe high", 32'(tx_valid), 1);
        chk("R11 strobe data", 32'(tx_data), 32'hA5);
        @(negedge clk);
        chk("R11 strobe one cycle", 32'(tx_valid), 0);
    endtask

    task automatic t_holes();
        logic seen_tx;
        rx_push(8'h3C);
        bus_write(8'h44, 32'h2);
        seen_tx = 1'b0;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] a;
            case (i)
                0: a = 8'h4C; 1: a = 8'h50; 2: a = 8'h5C;
                3: a = 8'h60; 4: a = 8'h68; default: a = 8'hC0;
            endcase
            bus_write(a, 32'hFFFF_FFFF);
            if (tx_valid) seen_tx = 1'b1;
        end
        chk("R12 no strobe from holes", 32'(seen_tx), 0);
        rd_chk("R12 enables untouched", 8'h44, 32'hC2);
        rd_chk("R12 queue untouched", 8'h64, xstat_exp());
        pop_chk("R12 byte intact");
        bus_write(8'h44, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enables();
        t_fixed();
        t_order();
        t_full_wrap();
        t_flush();
        t_tx();
        t_holes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule